// File: doc/BRIEF.md
# Bus Lock, Hold and Halt Controller

This block sits between a small processor execution core and its local bus. It keeps track of four pieces of processor state: whether the core has halted, whether a locked (indivisible) instruction sequence is in progress, whether the core is spinning in a wait-for-test loop, and whether an external master has been handed the bus. From a handful of core event strobes and external pins, it produces:

- a halt indication pulse (an address-latch strobe with no read or write qualifier),
- an active-low lock output,
- a bus hold grant and an output-float enable,
- wake and wait-complete pulses back to the core.

The external hold request passes through a flip-flop synchroniser. A grant is only given at a bus-cycle boundary reported by the core, and never while a lock is active. A request that arrives during a lock is remembered and honoured once the lock drops. A hold taken while halted keeps the core halted and signals the halt again when the bus is returned. An interrupt seen while the bus is held during a wait is delivered only once the bus is regained. The core then services it and restarts the wait.

Top module: `bus_lock_hold_ctl`

## Requirements
- R1: While `rst` is high, one clock edge sets `lock_n` high and drives `hold_grant`, `float_en`, `halt_ale`, `wake` and `wait_done` low. It also clears any pending hold request and any halt state.
- R2: A `halt_exec` strobe seen at a clock edge makes `halt_ale` high for exactly the following cycle. Only one pulse is given per halt entry.
- R3: A halted core is woken only by `nmi`, or by `irq` while `int_en` is high. The `wake` pulse is high for one cycle, starting at the edge that sees the cause. `irq` with `int_en` low leaves the core halted.
- R4: A hold granted while halted does not wake the core, even if a wake cause is present. One cycle after `hold_grant` falls, `halt_ale` pulses again. A wake cause still present is then honoured on the next edge.
- R5: `lock_n` goes low at the clock edge that samples `lock_prefix` high.
- R6: `lock_n` returns high at the clock edge that samples `instr_last_done` high, the end of the locked instruction's last bus cycle.
- R7: A hold request synchronised while `lock_n` is low is recorded and not granted. `hold_grant` rises on the edge after the one that releases the lock.
- R8: `hold_req` passes through two synchronising flops. With the bus idle and unlocked, `hold_grant` rises on the third edge after `hold_req` rises, and falls on the third edge after it falls. The grant never rises unless `bus_idle` was high in the previous cycle.
- R9: `float_en` is high exactly while `hold_grant` is high.
- R10: While `wait_exec` is high and the bus is not held, `wait_done` pulses on the edge after `test_n` is sampled low. It stays low while `test_n` is high.
- R11: While the bus is held, neither `wake` nor `wait_done` is raised. An enabled interrupt pending during a held wait raises `wake` one cycle after `hold_grant` falls. A wake cause takes priority over `wait_done`.
- R12: `rst` takes priority over `nmi`. A halted core that receives `nmi` in the same cycle as reset gives no `wake`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| halt_exec | input | 1 | Core strobe: halt instruction executed |
| lock_prefix | input | 1 | Core strobe: lock prefix decoded |
| instr_last_done | input | 1 | Core strobe: last bus cycle of the current instruction finished |
| wait_exec | input | 1 | Core level: wait-for-test instruction executing |
| bus_idle | input | 1 | Core level: bus is at a cycle boundary |
| hold_req | input | 1 | External hold request, asynchronous |
| test_n | input | 1 | Test input, active low |
| nmi | input | 1 | Non-maskable interrupt, level |
| irq | input | 1 | Maskable interrupt request |
| int_en | input | 1 | Interrupt-enable flag from the core |
| halt_ale | output | 1 | Halt indication: address-latch strobe without read or write |
| lock_n | output | 1 | Bus lock, active low |
| hold_grant | output | 1 | Bus handed to the external master |
| float_en | output | 1 | Float all bus outputs |
| wake | output | 1 | Pulse: leave halt or service an interrupt |
| wait_done | output | 1 | Pulse: test input seen low during a wait |

## Verification
The bench drives a hold request into a locked sequence. A controller that ignored the lock would grant mid-sequence, and one that dropped the request would never grant at all. It holds the bus during halt with an enabled interrupt pending, to catch a design that wakes during the hold or fails to re-signal halt afterwards. It also holds the bus during a wait with both an interrupt and a low test input present, to catch early delivery and a wrong priority between the two. The bench checks the exact latency of the two-flop synchroniser, a grant held off by a busy bus, and reset colliding with NMI, where a wrong priority would leak a wake pulse.

// File: rtl/bus_lhc_pkg.sv
package bus_lhc_pkg;

  typedef enum logic [1:0] {
    HS_RUN  = 2'd0,
    HS_HALT = 2'd1,
    HS_HELD = 2'd2
  } halt_st_e;

  // A halted or waiting core is released by NMI or an enabled interrupt.
  function automatic logic wake_evt_f(input logic nmi, input logic irq, input logic ie);
    return nmi | (irq & ie);
  endfunction

  // The bus may be handed over only when unlocked, no lock is starting and at a boundary.
  function automatic logic grant_ok_f(input logic want, input logic locked,
                                      input logic prefix, input logic idle);
    return want & ~locked & ~prefix & idle;
  endfunction

endpackage

// File: rtl/bus_lhc_sync.sv
module bus_lhc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[gi] <= 1'b0;
          else     chain[gi] <= chain[gi-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/bus_lhc_lock.sv
module bus_lhc_lock (
  input  logic clk,
  input  logic rst,
  input  logic lock_prefix,
  input  logic instr_last_done,
  output logic lock_active
);
  always_ff @(posedge clk) begin
    if (rst)                  lock_active <= 1'b0;
    else if (lock_prefix)     lock_active <= 1'b1;
    else if (instr_last_done) lock_active <= 1'b0;
  end
endmodule

// File: rtl/bus_lhc_arb.sv
module bus_lhc_arb
  import bus_lhc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hold_sync,
  input  logic lock_active,
  input  logic lock_prefix,
  input  logic bus_idle,
  output logic grant,
  output logic pend
);
  logic want;
  assign want = hold_sync | pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      grant <= 1'b0;
      pend  <= 1'b0;
    end else if (grant) begin
      grant <= hold_sync;
    end else if (grant_ok_f(want, lock_active, lock_prefix, bus_idle)) begin
      grant <= 1'b1;
      pend  <= 1'b0;
    end else if (hold_sync && lock_active) begin
      pend  <= 1'b1;
    end
  end
endmodule

// File: rtl/bus_lhc_halt.sv
module bus_lhc_halt
  import bus_lhc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic halt_exec,
  input  logic wait_exec,
  input  logic test_n,
  input  logic nmi,
  input  logic irq,
  input  logic int_en,
  input  logic grant,
  output logic halt_ale,
  output logic wake,
  output logic wait_done,
  output logic halt_held
);
  halt_st_e st;
  logic     evt;

  assign evt       = wake_evt_f(nmi, irq, int_en);
  assign halt_held = (st == HS_HELD);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= HS_RUN;
      halt_ale  <= 1'b0;
      wake      <= 1'b0;
      wait_done <= 1'b0;
    end else begin
      halt_ale  <= 1'b0;
      wake      <= 1'b0;
      wait_done <= 1'b0;
      unique case (st)
        HS_RUN: begin
          if (halt_exec) begin
            st       <= HS_HALT;
            halt_ale <= 1'b1;
          end else if (wait_exec && !grant) begin
            wake      <= evt;
            wait_done <= !test_n && !evt;
          end
        end
        HS_HALT: begin
          if (grant) begin
            st <= HS_HELD;
          end else if (evt) begin
            st   <= HS_RUN;
            wake <= 1'b1;
          end
        end
        HS_HELD: begin
          if (!grant) begin
            st       <= HS_HALT;
            halt_ale <= 1'b1;
          end
        end
        default: st <= HS_RUN;
      endcase
    end
  end
endmodule

// File: rtl/bus_lock_hold_ctl.sv
module bus_lock_hold_ctl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic halt_exec,
  input  logic lock_prefix,
  input  logic instr_last_done,
  input  logic wait_exec,
  input  logic bus_idle,
  input  logic hold_req,
  input  logic test_n,
  input  logic nmi,
  input  logic irq,
  input  logic int_en,
  output logic halt_ale,
  output logic lock_n,
  output logic hold_grant,
  output logic float_en,
  output logic wake,
  output logic wait_done
);
  logic hold_sync;
  logic lock_active;
  logic hold_pending;
  logic halt_held;

  bus_lhc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(hold_req), .q(hold_sync)
  );

  bus_lhc_lock u_lock (
    .clk(clk), .rst(rst), .lock_prefix(lock_prefix),
    .instr_last_done(instr_last_done), .lock_active(lock_active)
  );

  bus_lhc_arb u_arb (
    .clk(clk), .rst(rst), .hold_sync(hold_sync), .lock_active(lock_active),
    .lock_prefix(lock_prefix), .bus_idle(bus_idle),
    .grant(hold_grant), .pend(hold_pending)
  );

  bus_lhc_halt u_halt (
    .clk(clk), .rst(rst), .halt_exec(halt_exec), .wait_exec(wait_exec),
    .test_n(test_n), .nmi(nmi), .irq(irq), .int_en(int_en), .grant(hold_grant),
    .halt_ale(halt_ale), .wake(wake), .wait_done(wait_done), .halt_held(halt_held)
  );

  assign lock_n   = ~lock_active;
  assign float_en = hold_grant;
endmodule

// File: rtl/bus_lock_hold_ctl_chk.sv
module bus_lock_hold_ctl_chk (
  input logic clk,
  input logic rst,
  input logic lock_prefix,
  input logic instr_last_done,
  input logic bus_idle,
  input logic nmi,
  input logic irq,
  input logic int_en,
  input logic halt_ale,
  input logic lock_n,
  input logic hold_grant,
  input logic wake,
  input logic wait_done,
  input logic hold_pending,
  input logic halt_held
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (lock_n && !hold_grant && !halt_ale && !wake && !wait_done)); // R1
  AST_HALT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    halt_ale |=> !halt_ale); // R2
  AST_WAKE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    wake |-> $past(nmi || (irq && int_en))); // R3
  AST_HELD_REISSUE: assert property (@(posedge clk) disable iff (rst)
    $fell(halt_held) |-> halt_ale); // R4
  AST_LOCK_SET: assert property (@(posedge clk) disable iff (rst)
    lock_prefix |=> !lock_n); // R5
  AST_LOCK_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (instr_last_done && !lock_prefix) |=> lock_n); // R6
  AST_GRANT_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_grant) |-> lock_n); // R7
  AST_PEND_EXCL: assert property (@(posedge clk) disable iff (rst)
    hold_pending |-> !hold_grant); // R7
  AST_GRANT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_grant) |-> $past(bus_idle)); // R8
  AST_QUIET_HELD: assert property (@(posedge clk) disable iff (rst)
    $past(hold_grant) |-> (!wake && !wait_done)); // R11
endmodule

bind bus_lock_hold_ctl bus_lock_hold_ctl_chk u_chk (.*);

// File: tb/bus_lock_hold_ctl_tb.sv
module bus_lock_hold_ctl_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst, halt_exec, lock_prefix, instr_last_done, wait_exec, bus_idle;
  logic hold_req, test_n, nmi, irq, int_en;
  logic halt_ale, lock_n, hold_grant, float_en, wake, wait_done;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_lock_hold_ctl u_dut (
    .clk(clk), .rst(rst), .halt_exec(halt_exec), .lock_prefix(lock_prefix),
    .instr_last_done(instr_last_done), .wait_exec(wait_exec), .bus_idle(bus_idle),
    .hold_req(hold_req), .test_n(test_n), .nmi(nmi), .irq(irq), .int_en(int_en),
    .halt_ale(halt_ale), .lock_n(lock_n), .hold_grant(hold_grant),
    .float_en(float_en), .wake(wake), .wait_done(wait_done)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic halt_enter();
    halt_exec = 1'b1; tick(); halt_exec = 1'b0;
  endtask

  task automatic t_reset();
    chk(lock_n, 1'b1, "R1 lock_n");
    chk(hold_grant, 1'b0, "R1 grant");
    chk(float_en, 1'b0, "R1 float");
    chk(halt_ale, 1'b0, "R1 halt_ale");
    chk(wake, 1'b0, "R1 wake");
    chk(wait_done, 1'b0, "R1 wait_done");
  endtask

  task automatic t_halt_irq();
    halt_enter();
    chk(halt_ale, 1'b1, "R2 halt pulse");
    tick();
    chk(halt_ale, 1'b0, "R2 single pulse");
    irq = 1'b1; int_en = 1'b0;
    tick(3);
    chk(wake, 1'b0, "R3 masked irq");
    int_en = 1'b1;
    tick();
    chk(wake, 1'b1, "R3 enabled irq wakes");
    irq = 1'b0; int_en = 1'b0;
    tick();
    chk(wake, 1'b0, "R3 wake one cycle");
  endtask

  task automatic t_halt_nmi();
    halt_enter(); tick();
    nmi = 1'b1;
    tick();
    chk(wake, 1'b1, "R3 nmi wakes");
    nmi = 1'b0;
    tick();
  endtask

  task automatic t_halt_hold();
    halt_enter(); tick();
    hold_req = 1'b1;
    tick(3);
    chk(hold_grant, 1'b1, "R4 grant in halt");
    chk(float_en, 1'b1, "R9 float with grant");
    tick();
    irq = 1'b1; int_en = 1'b1;
    tick(2);
    chk(wake, 1'b0, "R4 no wake in hold");
    hold_req = 1'b0;
    tick(3);
    chk(hold_grant, 1'b0, "R4 grant released");
    chk(float_en, 1'b0, "R9 float released");
    chk(halt_ale, 1'b0, "R4 no early reissue");
    tick();
    chk(halt_ale, 1'b1, "R4 halt reissued");
    chk(wake, 1'b0, "R4 still halted");
    tick();
    chk(wake, 1'b1, "R4 wake after reissue");
    irq = 1'b0; int_en = 1'b0;
    tick();
  endtask

  task automatic t_lock();
    lock_prefix = 1'b1; tick(); lock_prefix = 1'b0;
    chk(lock_n, 1'b0, "R5 lock asserted");
    tick(2);
    chk(lock_n, 1'b0, "R5 lock held");
    instr_last_done = 1'b1; tick(); instr_last_done = 1'b0;
    chk(lock_n, 1'b1, "R6 lock released");
  endtask

  task automatic t_lock_hold();
    lock_prefix = 1'b1; tick(); lock_prefix = 1'b0;
    hold_req = 1'b1;
    tick(5);
    chk(hold_grant, 1'b0, "R7 no grant under lock");
    instr_last_done = 1'b1; tick(); instr_last_done = 1'b0;
    chk(lock_n, 1'b1, "R6 lock end");
    chk(hold_grant, 1'b0, "R7 grant not same edge");
    tick();
    chk(hold_grant, 1'b1, "R7 recorded request granted");
    hold_req = 1'b0;
    tick(3);
    chk(hold_grant, 1'b0, "R7 grant dropped");
  endtask

  task automatic t_sync_boundary();
    hold_req = 1'b1;
    tick(2);
    chk(hold_grant, 1'b0, "R8 two-flop latency");
    tick();
    chk(hold_grant, 1'b1, "R8 grant third edge");
    hold_req = 1'b0;
    tick(2);
    chk(hold_grant, 1'b1, "R8 release latency");
    tick();
    chk(hold_grant, 1'b0, "R8 release third edge");
    bus_idle = 1'b0; hold_req = 1'b1;
    tick(5);
    chk(hold_grant, 1'b0, "R8 busy bus blocks grant");
    bus_idle = 1'b1;
    tick();
    chk(hold_grant, 1'b1, "R8 grant at boundary");
    hold_req = 1'b0;
    tick(3);
  endtask

  task automatic t_wait();
    wait_exec = 1'b1; test_n = 1'b1;
    tick(3);
    chk(wait_done, 1'b0, "R10 waits on high test");
    test_n = 1'b0;
    tick();
    chk(wait_done, 1'b1, "R10 test low ends wait");
    wait_exec = 1'b0; test_n = 1'b1;
    tick();
    chk(wait_done, 1'b0, "R10 pulse ends");
  endtask

  task automatic t_wait_hold();
    wait_exec = 1'b1; test_n = 1'b1; hold_req = 1'b1;
    tick(3);
    chk(float_en, 1'b1, "R9 float during wait");
    irq = 1'b1; int_en = 1'b1; test_n = 1'b0;
    tick(2);
    chk(wake, 1'b0, "R11 irq deferred");
    chk(wait_done, 1'b0, "R11 test deferred");
    hold_req = 1'b0;
    tick(3);
    chk(hold_grant, 1'b0, "R11 bus regained");
    chk(wake, 1'b0, "R11 not same edge");
    tick();
    chk(wake, 1'b1, "R11 irq after regain");
    chk(wait_done, 1'b0, "R11 irq over test");
    irq = 1'b0; int_en = 1'b0;
    tick();
    chk(wait_done, 1'b1, "R11 wait restarted");
    wait_exec = 1'b0; test_n = 1'b1;
    tick();
  endtask

  task automatic t_reset_prio();
    lock_prefix = 1'b1; tick(); lock_prefix = 1'b0;
    halt_enter(); tick();
    nmi = 1'b1; rst = 1'b1;
    tick();
    chk(wake, 1'b0, "R12 reset beats nmi");
    chk(lock_n, 1'b1, "R1 lock cleared");
    chk(halt_ale, 1'b0, "R1 halt cleared");
    rst = 1'b0;
    tick();
    chk(wake, 1'b0, "R12 halt state gone");
    nmi = 1'b0;
    tick();
  endtask

  initial begin
    rst = 1'b1; halt_exec = 1'b0; lock_prefix = 1'b0; instr_last_done = 1'b0;
    wait_exec = 1'b0; bus_idle = 1'b1; hold_req = 1'b0; test_n = 1'b1;
    nmi = 1'b0; irq = 1'b0; int_en = 1'b0;
    tick(2);
    t_reset();
    rst = 1'b0;
    tick();
    t_halt_irq();
    t_halt_nmi();
    t_halt_hold();
    t_lock();
    t_lock_hold();
    t_sync_boundary();
    t_wait();
    t_wait_hold();
    t_reset_prio();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule